// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synchronous static memory core whose front end accepts a new read or write command on every rising clock edge. A read may follow a write, and a write may follow a read, with no idle cycle between them. Address, control, chip enables and byte selects are registered on the rising edge. Read data leaves the block in the cycle after its command, straight from the array, with no output register stage. Write data arrives on the clock edge after its command.

A one-entry delayed-write register holds each write until the array is updated. A read that targets the pending word takes the pending bytes from that register. A burst continues from one starting address through the other three words of its aligned group of four, in either linear or interleaved order. A clock enable freezes the whole pipeline. Output enable acts without a clock and gates only the driver-enable output.

Top module: `zt_sram`

## Requirements
- R1: While reset is high, and on the first cycle after reset, no command is active and `dq_drv` is 0.
- R2: A read command sampled at rising edge k drives the word stored at `addr` on `dq_out` in the same cycle, before edge k+1. `dq_drv` is high in that cycle if `out_en` is high.
- R3: A write command at edge k takes its data from `dq_in` at edge k+1. Bit i of `byte_sel` enables byte lane i, which is `dq[9i+8:9i]`.
- R4: A read that directly follows a write to the same address returns the newly written bytes, merged with the stored bytes where `byte_sel` was 0, with no dead cycle.
- R5: `dq_drv` is 0 during the data cycle of a write and during idle cycles, whatever the level of `out_en`.
- R6: `out_en` gates `dq_drv` combinationally, with no clock edge needed.
- R7: A new command is accepted only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. Any other combination deselects the block: no write happens and `dq_drv` stays 0.
- R8: While `clk_en`=0, no internal state changes. Outputs hold, and write data is not captured until the first enabled edge.
- R9: With `ilv_mode`=0 at the start of a burst, each `adv`=1 cycle moves to the next word of the aligned group of four, wrapping (start 2 gives 2,3,0,1).
- R10: With `ilv_mode`=1 at the start of a burst, the offset of beat n is the start offset XOR n (start 1 gives 1,0,3,2). The mode is held for the whole burst.
- R11: A cycle with `adv`=1 ignores `addr`, `wr_en` and the chip enables, and repeats the burst's operation. After a deselect, `adv`=1 leaves the block idle.
- R12: A write with `byte_sel`=0 leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable; 0 freezes all state |
| adv | input | 1 | 1 = continue the current burst |
| wr_en | input | 1 | Command type: 1 = write, 0 = read |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| ilv_mode | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| addr | input | ADDR_W | Word address |
| byte_sel | input | NBYTES | Active-high byte write selects |
| dq_in | input | NBYTES*BYTE_W | Write data, one cycle after its command |
| out_en | input | 1 | Asynchronous output enable |
| dq_out | output | NBYTES*BYTE_W | Flow-through read data |
| dq_drv | output | 1 | Enable for the external data driver |

## Verification
Several properties are checked on every cycle by the assertions. The driver enable never rises during a write data phase or without the output enable. A frozen clock leaves the command and pending-write state unchanged. A deselect empties the command stage, and a burst beat keeps its operation and its aligned group. The pending register is loaded exactly when a write command was present.

Data values can only be shown by the bench's scenarios. These include the bypass merge of a partially written word, the burst address sequences in both orders, and the fact that a deselected or zero-mask write leaves memory untouched. The bench also covers write data held back across a frozen clock and the asynchronous response of the driver enable.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // Offset of beat 'cnt' in a four-word group starting at 'start'
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] cnt,
        input logic              ilv
    );
        return ilv ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              adv,
    input  logic              wr_en,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              ilv_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTES-1:0] byte_sel,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [NBYTES-1:0] be_q
);
    localparam int BASE_W = ADDR_W - BEAT_W;

    logic [BASE_W-1:0] base_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] cnt_q;
    logic              ilv_q;
    logic              chip_on;

    assign chip_on = !en_a_n && en_b && !en_c_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_IDLE;
            base_q  <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            ilv_q   <= 1'b0;
            be_q    <= '0;
        end else if (clk_en) begin
            if (adv) begin
                if (op_q != OP_IDLE) begin
                    cnt_q <= cnt_q + 1'b1;
                    be_q  <= byte_sel;
                end
            end else if (chip_on) begin
                op_q    <= wr_en ? OP_WR : OP_RD;
                base_q  <= addr[ADDR_W-1:BEAT_W];
                start_q <= addr[BEAT_W-1:0];
                cnt_q   <= '0;
                ilv_q   <= ilv_mode;
                be_q    <= byte_sel;
            end else begin
                op_q <= OP_IDLE;
            end
        end
    end

    assign addr_q = {base_q, beat_offset(start_q, cnt_q, ilv_q)};

    AST_FROZEN_CMD: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(op_q) && $stable(cnt_q) && $stable(base_q))); // R8
    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !adv && !chip_on) |=> (op_q == OP_IDLE)); // R7
    AST_BEAT_KEEPS_OP: assert property (@(posedge clk) disable iff (rst)
        (clk_en && adv && op_q != OP_IDLE) |=> (op_q == $past(op_q))); // R11
    AST_BEAT_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
        (clk_en && adv && op_q != OP_IDLE) |=> (base_q == $past(base_q))); // R9

endmodule

// File: rtl/zt_sram_wbuf.sv
module zt_sram_wbuf
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clk_en,
    input  op_e                      op_q,
    input  logic [ADDR_W-1:0]        addr_q,
    input  logic [NBYTES-1:0]        be_q,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic [NBYTES*BYTE_W-1:0] arr_rdata,
    output logic                     wr_go,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [NBYTES-1:0]        wr_be,
    output logic [NBYTES*BYTE_W-1:0] wr_data,
    output logic [NBYTES*BYTE_W-1:0] rdata
);
    logic                     p_vld;
    logic [ADDR_W-1:0]        p_addr;
    logic [NBYTES-1:0]        p_be;
    logic [NBYTES*BYTE_W-1:0] p_data;
    logic                     hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_vld  <= 1'b0;
            p_addr <= '0;
            p_be   <= '0;
            p_data <= '0;
        end else if (clk_en) begin
            p_vld <= (op_q == OP_WR);
            if (op_q == OP_WR) begin
                p_addr <= addr_q;
                p_be   <= be_q;
                p_data <= wdata;
            end
        end
    end

    // The array takes the pending word on the edge that refills the register
    assign wr_go   = clk_en && p_vld;
    assign wr_addr = p_addr;
    assign wr_be   = p_be;
    assign wr_data = p_data;

    assign hit = p_vld && (p_addr == addr_q);

    for (genvar b = 0; b < NBYTES; b++) begin : g_merge
        assign rdata[b*BYTE_W +: BYTE_W] = (hit && p_be[b]) ?
            p_data[b*BYTE_W +: BYTE_W] : arr_rdata[b*BYTE_W +: BYTE_W];
    end

    AST_PEND_TRACKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        clk_en |=> (p_vld == ($past(op_q) == OP_WR))); // R3
    AST_PEND_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(p_vld) && $stable(p_data) && $stable(p_addr))); // R8

endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     wr_go,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES-1:0]        wr_be,
    input  logic [NBYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_go && wr_be[b]) begin
                lane_mem[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
            end
        end

        assign rd_data[b*BYTE_W +: BYTE_W] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clk_en,
    input  logic                     adv,
    input  logic                     wr_en,
    input  logic                     en_a_n,
    input  logic                     en_b,
    input  logic                     en_c_n,
    input  logic                     ilv_mode,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES-1:0]        byte_sel,
    input  logic [NBYTES*BYTE_W-1:0] dq_in,
    input  logic                     out_en,
    output logic [NBYTES*BYTE_W-1:0] dq_out,
    output logic                     dq_drv
);
    localparam int DATA_W = NBYTES * BYTE_W;

    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [NBYTES-1:0] be_q;
    logic              wr_go;
    logic [ADDR_W-1:0] wr_addr;
    logic [NBYTES-1:0] wr_be;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] arr_rdata;

    zt_sram_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .clk_en   (clk_en),
        .adv      (adv),
        .wr_en    (wr_en),
        .en_a_n   (en_a_n),
        .en_b     (en_b),
        .en_c_n   (en_c_n),
        .ilv_mode (ilv_mode),
        .addr     (addr),
        .byte_sel (byte_sel),
        .op_q     (op_q),
        .addr_q   (addr_q),
        .be_q     (be_q)
    );

    zt_sram_wbuf #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_wbuf (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .op_q      (op_q),
        .addr_q    (addr_q),
        .be_q      (be_q),
        .wdata     (dq_in),
        .arr_rdata (arr_rdata),
        .wr_go     (wr_go),
        .wr_addr   (wr_addr),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .rdata     (dq_out)
    );

    zt_sram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
        .clk     (clk),
        .wr_go   (wr_go),
        .wr_addr (wr_addr),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .rd_addr (addr_q),
        .rd_data (arr_rdata)
    );

    // Driver turns on only in the data cycle of a read
    assign dq_drv = out_en && (op_q == OP_RD);

    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_WR) |-> !dq_drv); // R5
    AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
        dq_drv |-> out_en); // R6

endmodule

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;

    typedef struct packed {
        logic [1:0]  kind;   // 0 deselected write, 1 read, 2 write
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [35:0] wd;
        logic [35:0] exp;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{2'd2, 8'h10, 4'hF, 36'h1_2345_6789, 36'h0},           // R3 full write
        '{2'd1, 8'h10, 4'h0, 36'h0, 36'h1_2345_6789},           // R4 bypass read
        '{2'd2, 8'h11, 4'hF, 36'h0, 36'h0},                     // R3
        '{2'd2, 8'h11, 4'h5, 36'hF_FFFF_FFFF, 36'h0},           // R3 lanes 0 and 2
        '{2'd1, 8'h11, 4'h0, 36'h0, 36'h0_07FC_01FF},           // R4 merged bytes
        '{2'd1, 8'h10, 4'h0, 36'h0, 36'h1_2345_6789},           // R2
        '{2'd2, 8'h10, 4'h0, 36'h0, 36'h0},                     // R12 empty mask
        '{2'd1, 8'h10, 4'h0, 36'h0, 36'h1_2345_6789},           // R12
        '{2'd0, 8'h10, 4'hF, 36'h0, 36'h0},                     // R7 deselected
        '{2'd1, 8'h10, 4'h0, 36'h0, 36'h1_2345_6789}            // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b1;
    logic        adv = 1'b0;
    logic        wr_en = 1'b0;
    logic        en_a_n = 1'b1;
    logic        en_b = 1'b0;
    logic        en_c_n = 1'b1;
    logic        ilv_mode = 1'b0;
    logic [7:0]  addr = '0;
    logic [3:0]  byte_sel = '0;
    logic [35:0] dq_in = '0;
    logic        out_en = 1'b1;
    logic [35:0] dq_out;
    logic        dq_drv;
    int          errors = 0;
    int          checks = 0;

    always #4 clk = ~clk;

    zt_sram u_zt_sram (
        .clk(clk), .rst(rst), .clk_en(clk_en), .adv(adv), .wr_en(wr_en),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .ilv_mode(ilv_mode),
        .addr(addr), .byte_sel(byte_sel), .dq_in(dq_in), .out_en(out_en),
        .dq_out(dq_out), .dq_drv(dq_drv)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic a, input logic w, input logic [7:0] ad, input logic [3:0] be);
        adv = a; wr_en = w; addr = ad; byte_sel = be;
        en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
    endtask

    task automatic idle();
        adv = 1'b0; wr_en = 1'b0; en_a_n = 1'b0; en_b = 1'b0; en_c_n = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [35:0] lin_exp [3];
        logic [35:0] ilv_exp [3];
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 drive after reset", {35'd0, dq_drv}, 36'd0);

        // table walk: command i is driven while data of command i-1 is on dq_in
        for (int i = 0; i <= NVEC; i++) begin
            @(negedge clk);
            if (i > 0) begin
                if (VEC[i-1].kind == 2'd1) begin
                    chk("R2 table read drive", {35'd0, dq_drv}, 36'd1);
                    chk("R2 table read data", dq_out, VEC[i-1].exp);
                end else begin
                    chk("R5 table write drive", {35'd0, dq_drv}, 36'd0);
                end
            end
            if (i < NVEC) begin
                cmd(1'b0, VEC[i].kind != 2'd1, VEC[i].addr, VEC[i].be);
                if (VEC[i].kind == 2'd0) en_b = 1'b0;
            end else begin
                idle();
            end
            dq_in = (i > 0) ? VEC[i-1].wd : 36'd0;
        end

        // fill group 0x20..0x23 back to back
        for (int k = 0; k < 4; k++) begin
            cmd(1'b0, 1'b1, 8'h20 + 8'(k), 4'hF);
            if (k > 0) dq_in = 36'h100 + 36'(k - 1);
            tick();
        end
        idle();
        dq_in = 36'h103;
        tick();

        // R9 linear from offset 2; R11 beats ignore addr and chip enables
        lin_exp = '{36'h103, 36'h100, 36'h101};
        ilv_mode = 1'b0;
        cmd(1'b0, 1'b0, 8'h22, 4'h0);
        tick();
        chk("R9 linear beat 0", dq_out, 36'h102);
        for (int b = 0; b < 3; b++) begin
            adv = 1'b1; en_b = 1'b0; addr = 8'h00; wr_en = 1'b1;
            tick();
            chk("R9 linear beat", dq_out, lin_exp[b]);
            chk("R11 beat keeps read", {35'd0, dq_drv}, 36'd1);
        end

        // R10 interleaved from offset 1, mode flipped mid-burst
        ilv_exp = '{36'h100, 36'h103, 36'h102};
        ilv_mode = 1'b1;
        cmd(1'b0, 1'b0, 8'h21, 4'h0);
        tick();
        chk("R10 interleaved beat 0", dq_out, 36'h101);
        for (int b = 0; b < 3; b++) begin
            adv = 1'b1; ilv_mode = 1'b0;
            tick();
            chk("R10 interleaved beat", dq_out, ilv_exp[b]);
        end

        // R11 advance after deselect stays idle
        idle();
        tick();
        adv = 1'b1;
        tick();
        chk("R11 adv after deselect", {35'd0, dq_drv}, 36'd0);

        // R8 frozen read
        cmd(1'b0, 1'b0, 8'h10, 4'h0);
        tick();
        chk("R2 read", dq_out, 36'h1_2345_6789);
        clk_en = 1'b0;
        cmd(1'b0, 1'b0, 8'h11, 4'h0);
        tick();
        chk("R8 frozen data", dq_out, 36'h1_2345_6789);
        clk_en = 1'b1;
        tick();
        chk("R8 resumed read", dq_out, 36'h0_07FC_01FF);

        // R8 write data held back across frozen cycle
        cmd(1'b0, 1'b1, 8'h13, 4'hF);
        tick();
        clk_en = 1'b0;
        dq_in = 36'hB_BBBB_BBBB;
        idle();
        tick();
        clk_en = 1'b1;
        dq_in = 36'hC_CCCC_CCCC;
        tick();
        cmd(1'b0, 1'b0, 8'h13, 4'h0);
        tick();
        chk("R8 write after freeze", dq_out, 36'hC_CCCC_CCCC);

        // R6 asynchronous output enable
        out_en = 1'b0;
        #1;
        chk("R6 oe low", {35'd0, dq_drv}, 36'd0);
        out_en = 1'b1;
        #1;
        chk("R6 oe high", {35'd0, dq_drv}, 36'd1);

        // R7 each chip enable alone blocks a write
        for (int j = 0; j < 3; j++) begin
            cmd(1'b0, 1'b1, 8'h10, 4'hF);
            if (j == 0) en_a_n = 1'b1;
            if (j == 1) en_b = 1'b0;
            if (j == 2) en_c_n = 1'b1;
            tick();
            chk("R7 deselect drive", {35'd0, dq_drv}, 36'd0);
            idle();
            dq_in = 36'd0;
            tick();
        end
        cmd(1'b0, 1'b0, 8'h10, 4'h0);
        tick();
        chk("R7 memory untouched", dq_out, 36'h1_2345_6789);

        // R1 reset in the middle of a read
        rst = 1'b1;
        tick();
        chk("R1 drive under reset", {35'd0, dq_drv}, 36'd0);
        rst = 1'b0;
        idle();
        tick();
        chk("R1 drive after reset", {35'd0, dq_drv}, 36'd0);

        finish_run();
    end

endmodule